// File: doc/BRIEF.md
# Trimmed-Rate Precision Time Counter

This block keeps a 64-bit time-of-day value counted in 8 ns ticks and lets software steer it. Every reference clock cycle a 32-bit rate word is added into a 31-bit fractional accumulator. The carry out of that sum, 0, 1 or 2, is the number of ticks added to the counter in that cycle. A rate word of 0x80000000 gives exactly one tick per cycle. Larger or smaller words run the counter proportionally faster or slower. Written rates are held inside a trim window of roughly ±3.2 % around nominal.

A simple one-cycle write / combinational read register port reaches four word registers. These are the rate word, the low and high halves of the clock value, and a 32-bit command word. One clock-value register serves two uses, picked by a mode flag in the command word that stays set until the command is rewritten. With the flag clear, a value write loads the counter. With it set, the value is signed and added to the counter. A command can also clear the counter. The schedule and pin-output command bits, meant for neighbouring blocks, are turned into one-cycle pulses.

Top module: `phc_trim_clock`

## Requirements
- R1: After reset the counter is 0, the rate word reads 0x80000000, the command state reads 0 (add mode off, timestamp-correction flag off) and all four pulse outputs are low.
- R2: With the rate word at 0x80000000 and no register write, the counter grows by exactly 1 tick per clock cycle.
- R3: Each cycle the rate word is added to a 31-bit fraction. Bits [32:31] of that 33-bit sum are the ticks added to the counter that cycle, and bits [30:0] become the new fraction. So over 64 cycles a rate of 0x84000000 adds 66 ticks and 0x7C000000 adds 62, whatever the fraction was at the start.
- R4: A rate write is clamped into [0x80000000 − TRIM_LIM, 0x80000000 + TRIM_LIM], with default TRIM_LIM 0x04189374 (0x7BE76C8C to 0x84189374). The stored and read-back value is the clamped one.
- R5: Register addresses are 0 rate, 1 clock value low word, 2 clock value high word, 3 command. A write to address 1 only stages the low word. A write to address 2 commits {high, staged low}. With add mode off, the counter holds exactly that value after the committing edge.
- R6: With add mode on, a commit adds the 64-bit two's-complement value to the counter in the same cycle as that cycle's normal tick increment, so no tick is lost.
- R7: Command bit 0 is the add-mode flag. It holds its value across any number of clock-value writes, until a valid command write changes it.
- R8: A valid command write with bit 3 set clears the counter to 0 (and the fraction to 0) at that edge.
- R9: A valid command write pulses outputs for one cycle, starting the cycle after the write: bit 30 drives sched_start_o, bit 29 sched_stop_o, bit 28 pin_start_o and bit 27 pin_stop_o.
- R10: Command bit 31 is the valid bit. A command write with it clear changes nothing: no pulse, no mode change, no counter clear.
- R11: Reads are combinational. Address 0 returns the rate word, 1 and 2 the low and high words of the live counter, and 3 the command state with add mode at bit 0 and timestamp correction at bit 2. time_o always shows the live counter.
- R12: Command bit 2 sets the timestamp-correction flag, which is driven on corr_ts_o as a level until the next valid command write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one accumulator step per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | 2 | Register address for write and read |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| time_o | output | 64 | Live tick counter |
| sched_start_o | output | 1 | One-cycle schedule start pulse |
| sched_stop_o | output | 1 | One-cycle schedule stop pulse |
| pin_start_o | output | 1 | One-cycle pin output start pulse |
| pin_stop_o | output | 1 | One-cycle pin output stop pulse |
| corr_ts_o | output | 1 | Timestamp-correction flag level |
| add_mode_o | output | 1 | Add-mode flag level |

## Verification
The assertions take for granted that reset is held for at least one edge and that the register port carries no more than one write per cycle. The nominal-step property also treats any write as a possible disturbance of the step, so it only judges cycles with the strobe low. The stimulus drives each write for exactly one cycle from the falling edge, with idle cycles between accesses. It keeps the rate at nominal except in the trim and clamp phases, so the nominal-step property is exercised over long idle stretches. The counter checks compare deltas measured at the ports against counts taken straight from the requirements, such as 66 or 62 ticks over 64 cycles, and do not rely on a running model.

// File: rtl/phc_pkg.sv
package phc_pkg;

   localparam int unsigned BUS_W = 32;
   localparam int unsigned ADR_W = 2;

   // register addresses
   localparam logic [ADR_W-1:0] ADR_RATE  = 2'd0;
   localparam logic [ADR_W-1:0] ADR_TLO   = 2'd1;
   localparam logic [ADR_W-1:0] ADR_THI   = 2'd2;
   localparam logic [ADR_W-1:0] ADR_CMD   = 2'd3;

   // command word bit positions (decoded by neighbouring blocks)
   localparam int unsigned CB_VALID   = 31;
   localparam int unsigned CB_SSTART  = 30;
   localparam int unsigned CB_SSTOP   = 29;
   localparam int unsigned CB_PSTART  = 28;
   localparam int unsigned CB_PSTOP   = 27;
   localparam int unsigned CB_CLEAR   = 3;
   localparam int unsigned CB_CORR    = 2;
   localparam int unsigned CB_ADD     = 0;

   typedef struct packed {
      logic valid;
      logic sched_start;
      logic sched_stop;
      logic pin_start;
      logic pin_stop;
      logic clear;
      logic corr;
      logic add;
   } cmd_fields_t;

   typedef struct packed {
      logic sched_start;
      logic sched_stop;
      logic pin_start;
      logic pin_stop;
   } cmd_pulse_t;

endpackage

// File: rtl/phc_rate_accum.sv
module phc_rate_accum #(
   parameter int unsigned         RATE_W   = 32,
   parameter logic [RATE_W-1:0]   TRIM_LIM = 32'h0418_9374,
   parameter bit                  CLAMP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rate_we_i,
   input  logic [RATE_W-1:0] rate_wdata_i,
   input  logic              acc_clr_i,
   output logic [RATE_W-1:0] rate_o,
   output logic [1:0]        inc_o
);

   localparam int unsigned       FRAC_W   = RATE_W - 1;
   localparam logic [RATE_W-1:0] RATE_NOM = {1'b1, {FRAC_W{1'b0}}};
   localparam logic [RATE_W-1:0] RATE_LO  = RATE_NOM - TRIM_LIM;
   localparam logic [RATE_W-1:0] RATE_HI  = RATE_NOM + TRIM_LIM;

   if (RATE_W < 8) begin : g_w_chk
      $error("phc_rate_accum: RATE_W too small");
   end
   if (TRIM_LIM >= RATE_NOM) begin : g_lim_chk
      $error("phc_rate_accum: TRIM_LIM must be below the nominal rate");
   end

   logic [RATE_W-1:0] rate_q;
   logic [RATE_W-1:0] rate_next;
   logic [FRAC_W-1:0] frac_q;
   logic [RATE_W:0]   acc_sum;

   generate
      if (CLAMP_EN) begin : g_clamp
         always_comb begin
            if (rate_wdata_i < RATE_LO)      rate_next = RATE_LO;
            else if (rate_wdata_i > RATE_HI) rate_next = RATE_HI;
            else                             rate_next = rate_wdata_i;
         end
      end else begin : g_pass
         assign rate_next = rate_wdata_i;
      end
   endgenerate

   assign acc_sum = {2'b00, frac_q} + {1'b0, rate_q};
   assign inc_o   = acc_sum[RATE_W:RATE_W-1];
   assign rate_o  = rate_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate_q <= RATE_NOM;
         frac_q <= '0;
      end else begin
         if (rate_we_i) rate_q <= rate_next;
         if (acc_clr_i) frac_q <= '0;
         else           frac_q <= acc_sum[FRAC_W-1:0];
      end
   end

   // R4
   rate_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      CLAMP_EN |-> (rate_q >= RATE_LO && rate_q <= RATE_HI));

endmodule

// File: rtl/phc_cmd_decode.sv
module phc_cmd_decode
   import phc_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_we_i,
   input  cmd_fields_t cmd_f_i,
   output cmd_pulse_t  pulses_o,
   output logic        add_mode_o,
   output logic        corr_ts_o,
   output logic        clr_o
);

   logic       accept;
   cmd_pulse_t pulses_q;
   logic       add_q;
   logic       corr_q;

   assign accept = cmd_we_i && cmd_f_i.valid;
   assign clr_o  = accept && cmd_f_i.clear;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulses_q <= '0;
         add_q    <= 1'b0;
         corr_q   <= 1'b0;
      end else begin
         pulses_q.sched_start <= accept && cmd_f_i.sched_start;
         pulses_q.sched_stop  <= accept && cmd_f_i.sched_stop;
         pulses_q.pin_start   <= accept && cmd_f_i.pin_start;
         pulses_q.pin_stop    <= accept && cmd_f_i.pin_stop;
         if (accept) begin
            add_q  <= cmd_f_i.add;
            corr_q <= cmd_f_i.corr;
         end
      end
   end

   assign pulses_o   = pulses_q;
   assign add_mode_o = add_q;
   assign corr_ts_o  = corr_q;

   // R9
   pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|pulses_q) |-> $past(cmd_we_i && cmd_f_i.valid));

   // R10
   invalid_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we_i && !cmd_f_i.valid) |=> ($stable(add_q) && $stable(corr_q) && pulses_q == '0));

endmodule

// File: rtl/phc_time_core.sv
module phc_time_core #(
   parameter int unsigned CNT_W  = 64,
   parameter int unsigned WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        inc_i,
   input  logic              clr_i,
   input  logic              stage_we_i,
   input  logic              commit_we_i,
   input  logic              add_mode_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [CNT_W-1:0]  cnt_o
);

   localparam int unsigned HI_W = CNT_W - WORD_W;

   if (CNT_W <= WORD_W || HI_W > WORD_W) begin : g_w_chk
      $error("phc_time_core: CNT_W must be between WORD_W+1 and 2*WORD_W");
   end

   logic [WORD_W-1:0] stage_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  cnt_d;
   logic [CNT_W-1:0]  stepped;
   logic [CNT_W-1:0]  operand;

   assign stepped = cnt_q + CNT_W'(inc_i);
   assign operand = {word_i[HI_W-1:0], stage_q};

   always_comb begin
      cnt_d = stepped;
      if (clr_i)            cnt_d = '0;
      else if (commit_we_i) cnt_d = add_mode_i ? (stepped + operand) : operand;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         cnt_q   <= '0;
      end else begin
         if (stage_we_i) stage_q <= word_i;
         cnt_q <= cnt_d;
      end
   end

   assign cnt_o = cnt_q;

   // R8
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_q == '0));

   // R3
   step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !commit_we_i) |=> ((cnt_q - $past(cnt_q)) <= CNT_W'(2)));

endmodule

// File: rtl/phc_trim_clock.sv
module phc_trim_clock
   import phc_pkg::*;
#(
   parameter int unsigned         CNT_W    = 64,
   parameter int unsigned         RATE_W   = 32,
   parameter logic [RATE_W-1:0]   TRIM_LIM = 32'h0418_9374,
   parameter bit                  CLAMP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADR_W-1:0]  bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic [CNT_W-1:0]  time_o,
   output logic              sched_start_o,
   output logic              sched_stop_o,
   output logic              pin_start_o,
   output logic              pin_stop_o,
   output logic              corr_ts_o,
   output logic              add_mode_o
);

   localparam logic [RATE_W-1:0] RATE_NOM = {1'b1, {(RATE_W-1){1'b0}}};

   if (RATE_W > BUS_W) begin : g_rate_chk
      $error("phc_trim_clock: RATE_W wider than the register port");
   end
   if (CNT_W != 2 * BUS_W) begin : g_cnt_chk
      $error("phc_trim_clock: CNT_W must span two register words");
   end

   logic              we_rate, we_lo, we_hi, we_cmd;
   logic [RATE_W-1:0] rate_w;
   logic [1:0]        inc_w;
   logic              clr_w;
   cmd_fields_t       cmd_f;
   cmd_pulse_t        pulses_w;
   logic [CNT_W-1:0]  cnt_w;

   assign we_rate = bus_wr && (bus_addr == ADR_RATE);
   assign we_lo   = bus_wr && (bus_addr == ADR_TLO);
   assign we_hi   = bus_wr && (bus_addr == ADR_THI);
   assign we_cmd  = bus_wr && (bus_addr == ADR_CMD);

   assign cmd_f.valid       = bus_wdata[CB_VALID];
   assign cmd_f.sched_start = bus_wdata[CB_SSTART];
   assign cmd_f.sched_stop  = bus_wdata[CB_SSTOP];
   assign cmd_f.pin_start   = bus_wdata[CB_PSTART];
   assign cmd_f.pin_stop    = bus_wdata[CB_PSTOP];
   assign cmd_f.clear       = bus_wdata[CB_CLEAR];
   assign cmd_f.corr        = bus_wdata[CB_CORR];
   assign cmd_f.add         = bus_wdata[CB_ADD];

   phc_rate_accum #(
      .RATE_W   (RATE_W),
      .TRIM_LIM (TRIM_LIM),
      .CLAMP_EN (CLAMP_EN)
   ) u_rate (
      .clk          (clk),
      .rst_n        (rst_n),
      .rate_we_i    (we_rate),
      .rate_wdata_i (bus_wdata[RATE_W-1:0]),
      .acc_clr_i    (clr_w),
      .rate_o       (rate_w),
      .inc_o        (inc_w)
   );

   phc_cmd_decode u_cmd (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_we_i   (we_cmd),
      .cmd_f_i    (cmd_f),
      .pulses_o   (pulses_w),
      .add_mode_o (add_mode_o),
      .corr_ts_o  (corr_ts_o),
      .clr_o      (clr_w)
   );

   phc_time_core #(
      .CNT_W  (CNT_W),
      .WORD_W (BUS_W)
   ) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .inc_i       (inc_w),
      .clr_i       (clr_w),
      .stage_we_i  (we_lo),
      .commit_we_i (we_hi),
      .add_mode_i  (add_mode_o),
      .word_i      (bus_wdata),
      .cnt_o       (cnt_w)
   );

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADR_RATE: bus_rdata = BUS_W'(rate_w);
         ADR_TLO:  bus_rdata = cnt_w[BUS_W-1:0];
         ADR_THI:  bus_rdata = cnt_w[CNT_W-1:BUS_W];
         default:  bus_rdata = BUS_W'({corr_ts_o, 1'b0, add_mode_o});
      endcase
   end

   assign time_o        = cnt_w;
   assign sched_start_o = pulses_w.sched_start;
   assign sched_stop_o  = pulses_w.sched_stop;
   assign pin_start_o   = pulses_w.pin_start;
   assign pin_stop_o    = pulses_w.pin_stop;

   // R2
   nominal_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_w == RATE_NOM && !bus_wr) |=> (time_o == $past(time_o) + CNT_W'(1)));

endmodule

// File: tb/phc_trim_clock_tb.sv
module phc_trim_clock_tb_top;
   import phc_pkg::*;

   typedef struct {
      int          kind;   // 0 rdata, 1 pulses, 2 time, 3 mode flags
      logic [63:0] exp;
      string       tag;
   } exp_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [63:0] time_o;
   logic        sched_start_o, sched_stop_o, pin_start_o, pin_stop_o;
   logic        corr_ts_o, add_mode_o;

   int          n_checks = 0;
   int          n_errs = 0;
   bit          done = 1'b0;
   exp_item_t   sb_q[$];
   logic [63:0] t0;

   always #5 clk = ~clk;

   phc_trim_clock dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .bus_wr        (bus_wr),
      .bus_addr      (bus_addr),
      .bus_wdata     (bus_wdata),
      .bus_rdata     (bus_rdata),
      .time_o        (time_o),
      .sched_start_o (sched_start_o),
      .sched_stop_o  (sched_stop_o),
      .pin_start_o   (pin_start_o),
      .pin_stop_o    (pin_stop_o),
      .corr_ts_o     (corr_ts_o),
      .add_mode_o    (add_mode_o)
   );

   // driver side
   task automatic push(input int kind, input logic [63:0] exp, input string tag);
      exp_item_t it;
      it.kind = kind;
      it.exp  = exp;
      it.tag  = tag;
      sb_q.push_back(it);
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr    = 1'b1;
      bus_addr  = a;
      bus_wdata = d;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic exp_read(input logic [1:0] a, input logic [31:0] d, input string tag);
      bus_addr = a;
      push(0, 64'(d), tag);
      @(negedge clk);
   endtask

   // monitor side
   always @(negedge clk) begin
      #2;
      while (sb_q.size() > 0) begin
         exp_item_t   it;
         logic [63:0] act;
         it = sb_q.pop_front();
         case (it.kind)
            0:       act = 64'(bus_rdata);
            1:       act = 64'({sched_start_o, sched_stop_o, pin_start_o, pin_stop_o});
            2:       act = time_o;
            default: act = 64'({corr_ts_o, add_mode_o});
         endcase
         n_checks++;
         if (act !== it.exp) begin
            n_errs++;
            $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
         end
      end
   end

   task automatic report();
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_errs++;
         $display("FAIL watchdog expired actual=running expected=finished");
         report();
         $finish;
      end
   end

   initial begin
      // R1 reset state
      repeat (3) tick();
      push(2, 64'd0, "R1 time in reset");
      push(1, 64'd0, "R1 pulses in reset");
      tick();
      rst_n = 1'b1;
      exp_read(ADR_RATE, 32'h8000_0000, "R1 rate after reset");
      exp_read(ADR_CMD, 32'h0, "R1 cmd state after reset");
      push(3, 64'd0, "R1 mode flags");

      // R2 nominal advance
      tick();
      t0 = time_o;
      repeat (10) tick();
      push(2, t0 + 64'd10, "R2 ten cycles nominal");

      // R5 absolute load, R11 read map
      bus_write(ADR_TLO, 32'h2222_1111);
      bus_write(ADR_THI, 32'h0000_0005);
      push(2, 64'h0000_0005_2222_1111, "R5 loaded value");
      exp_read(ADR_TLO, 32'h2222_1111, "R11 low word read");
      exp_read(ADR_THI, 32'h0000_0005, "R11 high word read");

      // R6 add mode, no tick lost
      bus_write(ADR_CMD, 32'h8000_0001);
      push(3, 64'd1, "R7 add mode set");
      t0 = time_o;
      bus_write(ADR_TLO, 32'h0000_0100);
      bus_write(ADR_THI, 32'h0000_0000);
      push(2, t0 + 64'd4 + 64'h100, "R6 positive add");

      // R7 mode persists, negative add
      t0 = time_o;
      bus_write(ADR_TLO, 32'hFFFF_FFC0);
      bus_write(ADR_THI, 32'hFFFF_FFFF);
      push(2, t0 + 64'd4 - 64'd64, "R7 second add negative");

      // R9 pulses
      bus_write(ADR_CMD, 32'h9000_0000);
      push(1, 64'b0010, "R9 pin start pulse");
      push(3, 64'd0, "R7 add mode cleared");
      tick();
      push(1, 64'b0000, "R9 pulse one cycle");
      bus_write(ADR_CMD, 32'hE800_0000);
      push(1, 64'b1101, "R9 sched start stop pin stop");
      tick();
      push(1, 64'b0000, "R9 pulses drop");

      // R10 valid clear ignored
      t0 = time_o;
      bus_write(ADR_CMD, 32'h7800_000D);
      push(1, 64'b0000, "R10 no pulse");
      push(3, 64'd0, "R10 mode unchanged");
      push(2, t0 + 64'd2, "R10 counter not cleared");

      // R12 correction flag
      bus_write(ADR_CMD, 32'h8000_0004);
      push(3, 64'b10, "R12 corr flag");
      exp_read(ADR_CMD, 32'h0000_0004, "R12 cmd read");

      // R8 clear
      bus_write(ADR_CMD, 32'h8000_0008);
      push(2, 64'd0, "R8 counter cleared");

      // R3 trimmed rates
      bus_write(ADR_RATE, 32'h8400_0000);
      t0 = time_o;
      repeat (64) tick();
      push(2, t0 + 64'd66, "R3 fast trim 64 cycles");
      bus_write(ADR_RATE, 32'h7C00_0000);
      t0 = time_o;
      repeat (64) tick();
      push(2, t0 + 64'd62, "R3 slow trim 64 cycles");
      exp_read(ADR_RATE, 32'h7C00_0000, "R11 rate read in range");

      // R4 clamp
      bus_write(ADR_RATE, 32'hFFFF_FFFF);
      exp_read(ADR_RATE, 32'h8418_9374, "R4 upper clamp");
      bus_write(ADR_RATE, 32'h0000_0000);
      exp_read(ADR_RATE, 32'h7BE7_6C8C, "R4 lower clamp");
      bus_write(ADR_RATE, 32'h8418_9375);
      exp_read(ADR_RATE, 32'h8418_9374, "R4 one above limit");
      bus_write(ADR_RATE, 32'h7BE7_6C8C);
      exp_read(ADR_RATE, 32'h7BE7_6C8C, "R4 exact lower limit");

      repeat (3) tick();
      if (!done) begin
         done = 1'b1;
         report();
         $finish;
      end
   end

endmodule